// File: doc/BRIEF.md
# Serial EEPROM Access Sequencer

This block drives a serial EEPROM over a four-wire SPI link so that the host side can read or program one byte at a time without knowing the memory's command set. The host presents an address, a direction and (for a program) a data byte, and strobes `start_i` for one cycle. The block latches the request, raises `busy_o`, and runs the needed chip-select frames on its own. When the last frame has closed, it drops `busy_o` and pulses `done_o` for one cycle.

A program request takes three frames. The first is a lone write-enable command. The second carries the write command, the address in two bytes and the data byte, and its closing edge starts the memory's internal program cycle. The block then keeps chip select high for a configurable number of clock cycles to cover the program time. The third frame is a lone write-disable command. A fetch request takes one frame: the read command, the address and a dummy zero byte. The byte shifted in from the memory during the dummy byte becomes `rdata_o`.

The serial clock runs in SPI mode 0 at the system clock divided by `CLK_DIV`. Chip select stays high for `GAP_CYCLES` cycles between frames and after the final frame, and for `PROG_CYCLES` cycles after a program frame.

Top module: `eeprom_spi_ctrl`

## Requirements
- R1: While reset is held and while idle, `cs_n_o`=1, `sck_o`=0, `mosi_o`=0, `busy_o`=0 and `done_o`=0. `rdata_o` resets to 0x00.
- R2: SPI mode 0. `sck_o` is low whenever `cs_n_o` is high. Each bit lasts `CLK_DIV` cycles: `sck_o` is low for the first half of the bit and high for the second half. `miso_i` is sampled on the clock edge that raises `sck_o`. While chip select stays low, `mosi_o` changes only on the cycle in which `sck_o` falls.
- R3: Each byte is shifted most significant bit first. The bytes of a frame follow each other with no idle bit between them, so a frame of n bytes holds `cs_n_o` low for n·8·`CLK_DIV` cycles.
- R4: A program request (`rw_i`=0) sends three frames in this order: [0x06], then [0x02, addr[15:8], addr[7:0], wdata], then [0x04].
- R5: A fetch request (`rw_i`=1) sends one frame: [0x03, addr[15:8], addr[7:0], 0x00]. The byte received during the 0x00 byte is loaded into `rdata_o` on the cycle that frame's chip select rises. At all other times `rdata_o` holds its value, including across program requests.
- R6: Chip select stays high for exactly `GAP_CYCLES` cycles after every frame, except after the program frame, when it stays high for exactly `PROG_CYCLES` cycles. `cs_n_o` falls and the first bit of the request appears on `mosi_o` in the cycle after `start_i` is sampled.
- R7: `busy_o` rises in the cycle after an accepted start and stays high through the closing chip-select gap of the last frame. It then falls, and in the same cycle `done_o` goes high for exactly one cycle.
- R8: `start_i` is ignored while `busy_o` is high, and a request that arrives during a transaction leaves no trace. A start sampled while `busy_o` is low, including the cycle in which `done_o` is high, begins a new request.
- R9: `mosi_o` is low whenever `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle request strobe |
| rw_i | input | 1 | 1 = fetch a byte, 0 = program a byte |
| addr_i | input | 16 | Memory byte address, latched at start |
| wdata_i | input | 8 | Byte to program, latched at start |
| rdata_o | output | 8 | Byte returned by the last fetch |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data to the memory |
| miso_i | input | 1 | Serial data from the memory |
| cs_n_o | output | 1 | Active-low memory chip select |

## Verification
The assertions assume that `miso_i` changes only while `sck_o` is low, as a mode-0 slave drives it, so the rising-edge sample always sees a settled bit. They also assume that `start_i` is not raised during the two synchronizer cycles after `rst_n` is released. The bench's memory model updates its data line only on falling serial-clock edges. The bench issues requests only after reset has been released for several cycles, and it deliberately pulses `start_i` in the middle of a program request to show that such a pulse is dropped.

// File: rtl/eeprom_spi_pkg.sv
`timescale 1ns/1ps
package eeprom_spi_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  // Command codes understood by the memory
  localparam logic [BYTE_W-1:0] CMD_WRITE  = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_READ   = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_WDIS   = 8'h04;
  localparam logic [BYTE_W-1:0] CMD_WEN    = 8'h06;
  localparam logic [BYTE_W-1:0] DUMMY_BYTE = 8'h00;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SHIFT,
    SEQ_HOLD
  } seq_state_e;

  typedef enum logic [1:0] {
    FRM_ENABLE,
    FRM_ACCESS,
    FRM_DISABLE
  } frame_e;

endpackage

// File: rtl/eeprom_rst_sync.sv
module eeprom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/eeprom_spi_shifter.sv
module eeprom_spi_shifter #(
  parameter int CLK_DIV = 16,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] tx_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              last_o,
  output logic [BYTE_W-1:0] rx_o
);

  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int HALF  = CLK_DIV / 2;

  logic              active_q, active_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              sck_q, sck_d;
  logic              rise_now, fall_now, run_en;

  assign rise_now = active_q && (div_q == DIV_W'(HALF - 1));
  assign fall_now = active_q && (div_q == DIV_W'(CLK_DIV - 1));
  assign last_o   = fall_now && (bit_q == BIT_W'(BYTE_W - 1));
  assign run_en   = active_q || load_i;

  always_comb begin
    active_d = active_q;
    div_d    = div_q;
    bit_d    = bit_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    sck_d    = sck_q;
    if (load_i) begin
      active_d = 1'b1;
      div_d    = '0;
      bit_d    = '0;
      tx_d     = tx_i;
      sck_d    = 1'b0;
    end else if (active_q) begin
      div_d = fall_now ? '0 : div_q + DIV_W'(1);
      if (rise_now) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[BYTE_W-2:0], miso_i};
      end
      if (fall_now) begin
        sck_d = 1'b0;
        tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
        bit_d = bit_q + BIT_W'(1);
        if (last_o) begin
          active_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sck_q    <= 1'b0;
    end else if (run_en) begin
      active_q <= active_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      sck_q    <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = active_q & tx_q[BYTE_W-1];
  assign rx_o   = rx_q;

endmodule

// File: rtl/eeprom_hold_timer.sv
module eeprom_hold_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expired_o = (cnt_q == '0);
  assign cnt_en    = load_i || !expired_o;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = count_i;
    end else if (!expired_o) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
  import eeprom_spi_pkg::*;
#(
  parameter int               CNT_W     = 20,
  parameter logic [CNT_W-1:0] GAP_LOAD  = '0,
  parameter logic [CNT_W-1:0] PROG_LOAD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              shift_last_i,
  input  logic [BYTE_W-1:0] rx_i,
  input  logic              timer_expired_i,
  output logic              shift_load_o,
  output logic [BYTE_W-1:0] shift_byte_o,
  output logic              timer_load_o,
  output logic [CNT_W-1:0]  timer_val_o,
  output logic              cs_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [BYTE_W-1:0] rdata_o
);

  seq_state_e        state_q, state_d;
  frame_e            frame_q, frame_d;
  logic [1:0]        idx_q, idx_d;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic [BYTE_W-1:0] rdata_q, rdata_d;

  logic              sel_rd;
  frame_e            sel_frame;
  frame_e            follow_frame;
  frame_e            final_frame;
  logic [1:0]        sel_idx;
  logic              accept;
  logic              seq_en;

  function automatic logic [1:0] frame_last_idx(input frame_e fr);
    return (fr == FRM_ACCESS) ? 2'd3 : 2'd0;
  endfunction

  function automatic logic [BYTE_W-1:0] frame_byte(
    input logic              rd,
    input frame_e            fr,
    input logic [1:0]        idx,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wd
  );
    logic [BYTE_W-1:0] b;
    b = DUMMY_BYTE;
    case (fr)
      FRM_ENABLE:  b = CMD_WEN;
      FRM_DISABLE: b = CMD_WDIS;
      default: begin
        case (idx)
          2'd0:    b = rd ? CMD_READ : CMD_WRITE;
          2'd1:    b = addr[ADDR_W-1:BYTE_W];
          2'd2:    b = addr[BYTE_W-1:0];
          default: b = rd ? DUMMY_BYTE : wd;
        endcase
      end
    endcase
    return b;
  endfunction

  assign accept       = (state_q == SEQ_IDLE) && start_i;
  assign follow_frame = (frame_q == FRM_ENABLE) ? FRM_ACCESS : FRM_DISABLE;
  assign final_frame  = rd_q ? FRM_ACCESS : FRM_DISABLE;

  always_comb begin
    state_d      = state_q;
    frame_d      = frame_q;
    idx_d        = idx_q;
    cs_n_d       = cs_n_q;
    done_d       = 1'b0;
    rdata_d      = rdata_q;
    shift_load_o = 1'b0;
    timer_load_o = 1'b0;
    timer_val_o  = GAP_LOAD;
    sel_rd       = rd_q;
    sel_frame    = frame_q;
    sel_idx      = idx_q + 2'd1;
    case (state_q)
      SEQ_IDLE: begin
        sel_rd    = rw_i;
        sel_frame = rw_i ? FRM_ACCESS : FRM_ENABLE;
        sel_idx   = 2'd0;
        if (start_i) begin
          state_d      = SEQ_SHIFT;
          frame_d      = sel_frame;
          idx_d        = 2'd0;
          cs_n_d       = 1'b0;
          shift_load_o = 1'b1;
        end
      end
      SEQ_SHIFT: begin
        if (shift_last_i) begin
          if (idx_q == frame_last_idx(frame_q)) begin
            state_d      = SEQ_HOLD;
            cs_n_d       = 1'b1;
            timer_load_o = 1'b1;
            if (!rd_q && frame_q == FRM_ACCESS) begin
              timer_val_o = PROG_LOAD;
            end
            if (rd_q) begin
              rdata_d = rx_i;
            end
          end else begin
            idx_d        = idx_q + 2'd1;
            shift_load_o = 1'b1;
          end
        end
      end
      SEQ_HOLD: begin
        sel_frame = follow_frame;
        sel_idx   = 2'd0;
        if (timer_expired_i) begin
          if (frame_q == final_frame) begin
            state_d = SEQ_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d      = SEQ_SHIFT;
            frame_d      = follow_frame;
            idx_d        = 2'd0;
            cs_n_d       = 1'b0;
            shift_load_o = 1'b1;
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign shift_byte_o = frame_byte(sel_rd, sel_frame, sel_idx, addr_q, wdata_q);
  assign seq_en       = (state_q != SEQ_IDLE) || start_i || done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      frame_q <= FRM_ENABLE;
      idx_q   <= '0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      frame_q <= frame_d;
      idx_q   <= idx_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      rd_q    <= rw_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  assign cs_n_o  = cs_n_q;
  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/eeprom_spi_ctrl.sv
module eeprom_spi_ctrl
  import eeprom_spi_pkg::*;
#(
  parameter int CLK_DIV     = 16,
  parameter int GAP_CYCLES  = 20,
  parameter int PROG_CYCLES = 1_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o
);

  localparam int               HOLD_MAX  = (PROG_CYCLES > GAP_CYCLES) ? PROG_CYCLES : GAP_CYCLES;
  localparam int               CNT_W     = $clog2(HOLD_MAX + 1);
  localparam logic [CNT_W-1:0] GAP_LOAD  = CNT_W'(GAP_CYCLES - 1);
  localparam logic [CNT_W-1:0] PROG_LOAD = CNT_W'(PROG_CYCLES - 1);

  logic              rst_n_sync;
  logic              shift_load;
  logic [BYTE_W-1:0] shift_byte;
  logic              shift_last;
  logic [BYTE_W-1:0] shift_rx;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic              timer_expired;

  eeprom_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_sync)
  );

  eeprom_cmd_seq #(
    .CNT_W     (CNT_W),
    .GAP_LOAD  (GAP_LOAD),
    .PROG_LOAD (PROG_LOAD)
  ) u_seq (
    .clk             (clk),
    .rst_n           (rst_n_sync),
    .start_i         (start_i),
    .rw_i            (rw_i),
    .addr_i          (addr_i),
    .wdata_i         (wdata_i),
    .shift_last_i    (shift_last),
    .rx_i            (shift_rx),
    .timer_expired_i (timer_expired),
    .shift_load_o    (shift_load),
    .shift_byte_o    (shift_byte),
    .timer_load_o    (timer_load),
    .timer_val_o     (timer_val),
    .cs_n_o          (cs_n_o),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .rdata_o         (rdata_o)
  );

  eeprom_spi_shifter #(
    .CLK_DIV (CLK_DIV),
    .BYTE_W  (BYTE_W)
  ) u_shifter (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .load_i (shift_load),
    .tx_i   (shift_byte),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .last_o (shift_last),
    .rx_o   (shift_rx)
  );

  eeprom_hold_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .load_i    (timer_load),
    .count_i   (timer_val),
    .expired_o (timer_expired)
  );

endmodule

// File: rtl/eeprom_spi_ctrl_chk.sv
module eeprom_spi_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [7:0] rdata_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       sck_o,
  input logic       mosi_o,
  input logic       cs_n_o
);

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sck_o);

  assert_mosi_moves_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o) && !$fell(sck_o)) |-> $stable(mosi_o));

  assert_mosi_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !mosi_o);

  assert_rdata_only_at_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> $rose(cs_n_o));

  assert_frame_inside_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_start_accepted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && !cs_n_o));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (busy_o || done_o));

endmodule

bind eeprom_spi_ctrl eeprom_spi_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .rdata_o (rdata_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sck_o   (sck_o),
  .mosi_o  (mosi_o),
  .cs_n_o  (cs_n_o)
);

// File: tb/eeprom_spi_ctrl_tb.sv
module eeprom_spi_ctrl_tb;

  localparam int CLK_DIV = 16;
  localparam int GAP     = 20;
  localparam int PROG    = 300;

  typedef struct packed {
    logic cs_n;
    logic sck;
    logic mosi;
    logic busy;
    logic done;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        rw_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  rdata_o;
  logic        busy_o, done_o, sck_o, mosi_o, cs_n_o;
  logic        miso_i = 1'b0;

  int n_checks = 0;
  int n_err    = 0;

  exp_t       exp_q[$];
  bit         cur_busy = 1'b0;
  logic [7:0] ref_mem[int];
  logic [7:0] last_rd = 8'h00;

  // Behavioural memory on the serial side
  logic [31:0] ee_shift = '0;
  int          ee_bits  = 0;
  bit          ee_wel   = 1'b0;
  logic [7:0]  ee_resp  = 8'hFF;
  logic [7:0]  ee_mem[int];

  always #2.5 clk = ~clk;

  eeprom_spi_ctrl #(
    .CLK_DIV     (CLK_DIV),
    .GAP_CYCLES  (GAP),
    .PROG_CYCLES (PROG)
  ) u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .rw_i    (rw_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o),
    .miso_i  (miso_i),
    .cs_n_o  (cs_n_o)
  );

  always @(negedge cs_n_o) ee_bits = 0;

  always @(posedge sck_o) begin
    if (!cs_n_o) begin
      ee_shift = {ee_shift[30:0], mosi_o};
      ee_bits  = ee_bits + 1;
    end
  end

  always @(negedge sck_o) begin
    if (!cs_n_o && ee_bits >= 24 && ee_bits < 32) begin
      if (ee_bits == 24) begin
        ee_resp = ee_mem.exists(int'(ee_shift[15:0])) ? ee_mem[int'(ee_shift[15:0])] : 8'hFF;
      end
      miso_i = ee_resp[31 - ee_bits];
    end
  end

  always @(posedge cs_n_o) begin
    if (ee_bits == 8 && ee_shift[7:0] == 8'h06) ee_wel = 1'b1;
    if (ee_bits == 8 && ee_shift[7:0] == 8'h04) ee_wel = 1'b0;
    if (ee_bits == 32 && ee_shift[31:24] == 8'h02 && ee_wel)
      ee_mem[int'(ee_shift[23:8])] = ee_shift[7:0];
    miso_i = 1'b0;
  end

  function automatic exp_t mk(input logic c, input logic s, input logic m,
                              input logic b, input logic d);
    exp_t e;
    e.cs_n = c; e.sck = s; e.mosi = m; e.busy = b; e.done = d;
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic compare_cycle();
    exp_t e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cur_busy = e.busy;
    chk(cs_n_o === e.cs_n, "R6", "cs_n", int'(cs_n_o), int'(e.cs_n));
    chk(sck_o === e.sck, "R2", "sck", int'(sck_o), int'(e.sck));
    chk(mosi_o === e.mosi, e.cs_n ? "R9" : "R3", "mosi", int'(mosi_o), int'(e.mosi));
    chk(busy_o === e.busy, "R7", "busy", int'(busy_o), int'(e.busy));
    chk(done_o === e.done, "R7", "done", int'(done_o), int'(e.done));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_cycle();
  endtask

  task automatic push_byte(input logic [7:0] b);
    for (int j = 0; j < 8 * CLK_DIV; j++)
      exp_q.push_back(mk(1'b0, (j % CLK_DIV) >= CLK_DIV / 2, b[7 - j / CLK_DIV], 1'b1, 1'b0));
  endtask

  task automatic push_hold(input int n);
    for (int j = 0; j < n; j++) exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
  endtask

  // Issue a request right after a compare; expected waveform only if idle
  task automatic start_txn(input bit rd, input logic [15:0] a, input logic [7:0] d);
    start_i = 1'b1; rw_i = rd; addr_i = a; wdata_i = d;
    if (!cur_busy) begin
      if (rd) begin
        push_byte(8'h03); push_byte(a[15:8]); push_byte(a[7:0]); push_byte(8'h00);
        push_hold(GAP);
      end else begin
        push_byte(8'h06); push_hold(GAP);
        push_byte(8'h02); push_byte(a[15:8]); push_byte(a[7:0]); push_byte(d);
        push_hold(PROG);
        push_byte(8'h04); push_hold(GAP);
        ref_mem[int'(a)] = d;
      end
      exp_q.push_back(mk(1'b1, 1'b0, 1'b0, 1'b0, 1'b1));
    end
    tick();
    start_i = 1'b0; addr_i = ~a; wdata_i = ~d; rw_i = ~rd;
  endtask

  task automatic finish_txn();
    while (exp_q.size() > 0) tick();
  endtask

  task automatic run_txn(input bit rd, input logic [15:0] a, input logic [7:0] d);
    logic [7:0] want;
    start_txn(rd, a, d);
    finish_txn();
    if (rd) begin
      want = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'hFF;
      chk(rdata_o === want, "R5", "rdata", int'(rdata_o), int'(want));
      last_rd = want;
    end else begin
      chk(ee_mem.exists(int'(a)) && ee_mem[int'(a)] == d, "R4", "programmed byte",
          ee_mem.exists(int'(a)) ? int'(ee_mem[int'(a)]) : -1, int'(d));
      chk(ee_wel == 1'b0, "R4", "write latch closed", int'(ee_wel), 0);
      chk(rdata_o === last_rd, "R5", "rdata held over program", int'(rdata_o), int'(last_rd));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R7 watchdog actual=running expected=finished at %0t", $time);
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; rw_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) tick();
    // R1 reset values
    chk(cs_n_o === 1'b1, "R1", "cs_n in reset", int'(cs_n_o), 1);
    chk(sck_o === 1'b0, "R1", "sck in reset", int'(sck_o), 0);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1", "busy/done in reset",
        int'({busy_o, done_o}), 0);
    chk(rdata_o === 8'h00, "R1", "rdata in reset", int'(rdata_o), 0);
    rst_n = 1'b1;
    repeat (5) tick();
    chk(cs_n_o === 1'b1 && mosi_o === 1'b0, "R1", "idle lines", int'({cs_n_o, mosi_o}), 2);

    run_txn(1'b1, 16'h1234, 8'h00);   // R5 unwritten location reads 0xFF
    run_txn(1'b0, 16'h1234, 8'hA5);   // R4 program
    run_txn(1'b1, 16'h1234, 8'h00);   // R5 read back
    run_txn(1'b0, 16'hFFFF, 8'h3C);   // R8 next start lands in the done cycle
    run_txn(1'b0, 16'h0000, 8'hC3);
    run_txn(1'b1, 16'hFFFF, 8'h00);
    run_txn(1'b1, 16'h0000, 8'h00);

    // R8 a start pulse in the middle of a program request is dropped
    start_txn(1'b0, 16'h0100, 8'h11);
    repeat (200) tick();
    start_txn(1'b0, 16'h0777, 8'h99);
    finish_txn();
    chk(!ee_mem.exists(32'h0777), "R8", "ignored request reached memory",
        int'(ee_mem.exists(32'h0777)), 0);
    chk(ee_mem.exists(32'h0100) && ee_mem[32'h0100] == 8'h11, "R8", "running request intact",
        ee_mem.exists(32'h0100) ? int'(ee_mem[32'h0100]) : -1, 8'h11);
    repeat (10) tick();
    chk(busy_o === 1'b0, "R8", "idle after ignored start", int'(busy_o), 0);
    run_txn(1'b1, 16'h0100, 8'h00);

    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule